// File: doc/BRIEF.md
# Timer Event Flag Register

This block holds the eight event flags raised by a set of timers: the 16-bit main timer and two smaller neighbours. It watches the main timer's count against two compare values and a capture/TOP value, takes the capture-pin strobe and the overflow strobe from that timer, and takes the neighbours' four events as plain set pulses. Each event latches into its own bit of a status byte, and each bit drives an interrupt request line through a per-bit enable mask.

A flag is removed in one of two ways: software writes a one to its bit position, or the interrupt controller pulses that bit's acknowledge line when it enters the handler. A hardware event always wins over a clear landing in the same cycle, so no event goes missing. Compare flags are deliberately one timer tick late: the equality is seen on one tick and the flag appears on the next. Each equality is counted once, however long the count sits on the compare value.

Top module: `tmr_flag_reg`

## Requirements
- R1: After a cycle with `rst_n` low, `flags_o` and `irq_o` are all zero.
- R2: Bit positions are fixed: bit 7 second-timer compare, bit 6 second-timer overflow, bit 5 capture/TOP, bit 4 compare A, bit 3 compare B, bit 2 main overflow, bit 1 first-timer compare, bit 0 first-timer overflow; a pulse on a neighbour set input (bits 7, 6, 1, 0) sets that bit at the next clock edge.
- R3: With `top_from_icr_i` low, a pulse on `cap_evt_i` sets bit 5 at the next clock edge.
- R4: With `top_from_icr_i` high, `cap_evt_i` has no effect and bit 5 sets at the edge closing a `tick_i` cycle in which `count_i` equals `icr_i` for the first tick of that equality.
- R5: When `count_i` equals a compare value (`ocr_a_i` for bit 4, `ocr_b_i` for bit 3) in a `tick_i` cycle, the flag stays clear through that edge and every non-tick cycle after it, and sets at the edge closing the next `tick_i` cycle.
- R6: An equality that persists over consecutive ticks sets its flag only once; after it is cleared it does not set again until the count has left and returned to the compare value on a tick.
- R7: `force_a_i` and `force_b_i` never set any flag.
- R8: A pulse on `ovf_evt_i` sets bit 2 only while `ovf_mode_i` is high (normal or clear-on-compare waveform mode); otherwise it is ignored.
- R9: With `wr_en_i` high, each one in `wr_data_i` clears the matching flag at the next edge; each zero leaves its flag unchanged.
- R10: A one on `ack_i[n]` clears flag n at the next edge.
- R11: A set event and a clear (write-one or acknowledge) on the same flag in the same cycle leave the flag set.
- R12: `irq_o[n]` is high exactly when flag n and `mask_i[n]` are both high, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timer clock enable, one cycle per timer tick |
| count_i | input | 16 | Current main timer count |
| ocr_a_i | input | 16 | Compare value, channel A |
| ocr_b_i | input | 16 | Compare value, channel B |
| icr_i | input | 16 | Capture register value (TOP when selected) |
| top_from_icr_i | input | 1 | Waveform mode uses capture register as TOP |
| cap_evt_i | input | 1 | Capture-pin event strobe |
| ovf_evt_i | input | 1 | Main timer overflow strobe |
| ovf_mode_i | input | 1 | High in normal or clear-on-compare mode |
| force_a_i | input | 1 | Forced compare strobe, channel A |
| force_b_i | input | 1 | Forced compare strobe, channel B |
| t2_cmp_set_i | input | 1 | Second timer compare event |
| t2_ovf_set_i | input | 1 | Second timer overflow event |
| t0_cmp_set_i | input | 1 | First timer compare event |
| t0_ovf_set_i | input | 1 | First timer overflow event |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data, ones clear flags |
| ack_i | input | 8 | Per-flag interrupt acknowledge |
| mask_i | input | 8 | Per-flag interrupt enable |
| flags_o | output | 8 | Flag byte |
| irq_o | output | 8 | Per-flag interrupt requests |

## Verification
The compare path is driven three ways: ticks every cycle, ticks spaced several cycles apart, and a count frozen on the compare value across many ticks; the first shows the one-tick lag, the second separates a lag measured in ticks from one measured in clocks, and the third separates a one-shot detector from a level detector. Capture is tried with the pin strobe in both TOP settings, which tells the two sources of bit 5 apart. Clears are exercised by write-one, write-zero and acknowledge, each alone and each colliding with a set, so priority errors show. A long seeded random run with counts confined to a small range makes matches, overflows and clears collide often, checked against a bench model of every bit.

// File: rtl/tfr_pkg.sv
// Shared definitions for the timer event flag register.
// Assumes an 8-bit flag byte; bit positions are decoded by software,
// so they are fixed here and not parameters.
package tfr_pkg;
    localparam int FLAG_W   = 8;
    localparam int CNT_W    = 16;

    localparam int B_T2_CMP = 7;
    localparam int B_T2_OVF = 6;
    localparam int B_CAP    = 5;
    localparam int B_CMP_A  = 4;
    localparam int B_CMP_B  = 3;
    localparam int B_OVF    = 2;
    localparam int B_T0_CMP = 1;
    localparam int B_T0_OVF = 0;

    typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/tfr_match.sv
// Equality detector for a timer count against a reference value.
// Fires once per equality: a held flop remembers that the equality was
// already seen on the last tick. With DELAY=1 the hit is parked in a
// pending flop and released on the following tick.
// Assumes tick_i is a single-cycle enable per timer tick.
module tfr_match #(
    parameter int W     = 16,
    parameter int DELAY = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] ref_i,
    output logic         hit_o
);
    logic eq;
    logic held_q;
    logic fresh;

    assign eq    = (count_i == ref_i);
    assign fresh = tick_i && eq && !held_q;

    // Remember the equality state seen on the latest tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (tick_i) begin
            held_q <= eq;
        end
    end

    generate
        if (DELAY != 0) begin : g_late
            logic pend_q;

            // Park a fresh match until the next tick.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q <= 1'b0;
                end else if (tick_i) begin
                    pend_q <= fresh;
                end
            end

            assign hit_o = tick_i && pend_q;
        end else begin : g_now
            assign hit_o = fresh;
        end
    endgenerate
endmodule

// File: rtl/tfr_flag_bank.sv
// Bank of sticky flag bits. Each bit sets on its set input and clears on
// its clear input; set has priority so a colliding event is kept.
module tfr_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic q;

            // Hold one flag: set beats clear, otherwise keep.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= 1'b0;
                end else if (set_i[i]) begin
                    q <= 1'b1;
                end else if (clr_i[i]) begin
                    q <= 1'b0;
                end
            end

            assign flag_o[i] = q;
        end
    endgenerate
endmodule

// File: rtl/tfr_irq_gate.sv
// Combinational interrupt request gating: one request per flag,
// qualified by its enable bit. No registers, so requests follow the
// flags in the same cycle.
module tfr_irq_gate #(
    parameter int N = 8
) (
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] req_o
);
    // Qualify each flag with its enable.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            req_o[i] = flag_i[i] & en_i[i];
        end
    end
endmodule

// File: rtl/tmr_flag_reg.sv
// Timer event flag register, top level.
// Collects the main timer's capture, compare and overflow events and the
// neighbour timers' raw events into one flag byte with write-one-to-clear
// and per-bit acknowledge clear, then gates interrupt requests by mask.
// Assumes the counter, waveform logic and neighbour timers live outside.
// Forced compare strobes are accepted but, by rule, never raise a flag.
module tmr_flag_reg
    import tfr_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [CW-1:0]     count_i,
    input  logic [CW-1:0]     ocr_a_i,
    input  logic [CW-1:0]     ocr_b_i,
    input  logic [CW-1:0]     icr_i,
    input  logic              top_from_icr_i,
    input  logic              cap_evt_i,
    input  logic              ovf_evt_i,
    input  logic              ovf_mode_i,
    input  logic              force_a_i,
    input  logic              force_b_i,
    input  logic              t2_cmp_set_i,
    input  logic              t2_ovf_set_i,
    input  logic              t0_cmp_set_i,
    input  logic              t0_ovf_set_i,
    input  logic              wr_en_i,
    input  logic [FLAG_W-1:0] wr_data_i,
    input  logic [FLAG_W-1:0] ack_i,
    input  logic [FLAG_W-1:0] mask_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] irq_o
);
    logic      hit_a;
    logic      hit_b;
    logic      hit_top;
    logic      cap_set;
    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    logic      unused_force;

    // Forced compares have no path to any flag.
    assign unused_force = force_a_i | force_b_i;

    tfr_match #(.W(CW), .DELAY(1)) u_cmp_a (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .count_i(count_i), .ref_i(ocr_a_i), .hit_o(hit_a)
    );

    tfr_match #(.W(CW), .DELAY(1)) u_cmp_b (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .count_i(count_i), .ref_i(ocr_b_i), .hit_o(hit_b)
    );

    tfr_match #(.W(CW), .DELAY(0)) u_top (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .count_i(count_i), .ref_i(icr_i), .hit_o(hit_top)
    );

    // Pick the capture flag source from the TOP selection.
    always_comb begin
        cap_set = top_from_icr_i ? hit_top : cap_evt_i;
    end

    // Assemble per-bit set and clear requests.
    always_comb begin
        set_vec           = '0;
        set_vec[B_T2_CMP] = t2_cmp_set_i;
        set_vec[B_T2_OVF] = t2_ovf_set_i;
        set_vec[B_CAP]    = cap_set;
        set_vec[B_CMP_A]  = hit_a;
        set_vec[B_CMP_B]  = hit_b;
        set_vec[B_OVF]    = ovf_evt_i && ovf_mode_i;
        set_vec[B_T0_CMP] = t0_cmp_set_i;
        set_vec[B_T0_OVF] = t0_ovf_set_i;
        clr_vec           = (wr_en_i ? wr_data_i : '0) | ack_i;
    end

    tfr_flag_bank #(.N(FLAG_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .set_i(set_vec), .clr_i(clr_vec), .flag_o(flags_o)
    );

    tfr_irq_gate #(.N(FLAG_W)) u_irq (
        .flag_i(flags_o), .en_i(mask_i), .req_o(irq_o)
    );
endmodule

// File: rtl/tfr_checker.sv
// Port-level properties of the timer event flag register, bound to the top.
module tfr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic        ovf_evt_i,
    input logic        ovf_mode_i,
    input logic        force_a_i,
    input logic        t0_ovf_set_i,
    input logic        t2_ovf_set_i,
    input logic        wr_en_i,
    input logic [7:0]  wr_data_i,
    input logic [7:0]  ack_i,
    input logic [7:0]  mask_i,
    input logic [7:0]  flags_o,
    input logic [7:0]  irq_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (flags_o == 8'h00));

    assert_cmp_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[4]) |-> $past(tick_i));

    assert_force_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (force_a_i && !tick_i && !ack_i[4] && !(wr_en_i && wr_data_i[4]))
        |=> (flags_o[4] == $past(flags_o[4])));

    assert_ovf_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[2]) |-> $past(ovf_evt_i && ovf_mode_i));

    assert_write_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[0] && !t0_ovf_set_i) |=> !flags_o[0]);

    assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i[6] && !t2_ovf_set_i) |=> !flags_o[6]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_ovf_set_i && ((wr_en_i && wr_data_i[0]) || ack_i[0])) |=> flags_o[0]);

    assert_irq_needs_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~flags_o) == 8'h00);

    assert_irq_needs_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~mask_i) == 8'h00);
endmodule

bind tmr_flag_reg tfr_checker u_chk (.*);

// File: tb/sim_tmr_flag_reg.sv
module sim_tmr_flag_reg;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic [15:0] cnt, oa, ob, icr;
    logic        cit, cap, ovf, omode, fa, fb;
    logic        t2c, t2o, t0c, t0o;
    logic        wr;
    logic [7:0]  wd, ack, mask;
    logic [7:0]  flags, irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    // Bench model state
    logic [7:0] exp_f;
    logic hA, hB, hT, pA, pB;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_flag_reg u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .count_i(cnt),
        .ocr_a_i(oa), .ocr_b_i(ob), .icr_i(icr), .top_from_icr_i(cit),
        .cap_evt_i(cap), .ovf_evt_i(ovf), .ovf_mode_i(omode),
        .force_a_i(fa), .force_b_i(fb), .t2_cmp_set_i(t2c),
        .t2_ovf_set_i(t2o), .t0_cmp_set_i(t0c), .t0_ovf_set_i(t0o),
        .wr_en_i(wr), .wr_data_i(wd), .ack_i(ack), .mask_i(mask),
        .flags_o(flags), .irq_o(irq)
    );

    function automatic string req_of(int b);
        case (b)
            5:       return "R3/R4";
            4, 3:    return "R5/R6";
            2:       return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG_LIMIT && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected < %0d", cycles, WDOG_LIMIT);
            report();
        end
    end

    task automatic quiet();
        tick = 0; cap = 0; ovf = 0; fa = 0; fb = 0;
        t2c = 0; t2o = 0; t0c = 0; t0o = 0; wr = 0; wd = 0; ack = 0;
    endtask

    // Advance one clock: update model from current inputs, then compare.
    task automatic step(string tag);
        logic [7:0] s, c;
        logic mA, mB, mT;
        mA = tick && (cnt == oa) && !hA;
        mB = tick && (cnt == ob) && !hB;
        mT = tick && (cnt == icr) && !hT;
        s = '0;
        s[7] = t2c; s[6] = t2o; s[5] = cit ? mT : cap;
        s[4] = tick && pA; s[3] = tick && pB; s[2] = ovf && omode;
        s[1] = t0c; s[0] = t0o;
        c = (wr ? wd : 8'h00) | ack;
        if (rst_n) begin
            exp_f = s | (exp_f & ~c);
            if (tick) begin
                hA = (cnt == oa); hB = (cnt == ob); hT = (cnt == icr);
                pA = mA; pB = mB;
            end
        end else begin
            exp_f = '0; hA = 0; hB = 0; hT = 0; pA = 0; pB = 0;
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
        n_chk++;
        if (flags !== exp_f) begin
            n_bad++;
            for (int b = 0; b < 8; b++)
                if (flags[b] !== exp_f[b])
                    $display("FAIL %s %s bit %0d: actual %b expected %b",
                             tag, req_of(b), b, flags[b], exp_f[b]);
        end
        n_chk++;
        if (irq !== (exp_f & mask)) begin
            n_bad++;
            $display("FAIL %s R12 irq: actual %h expected %h", tag, irq, exp_f & mask);
        end
    endtask

    task automatic expect_bit(int b, logic v, string tag);
        n_chk++;
        if (flags[b] !== v) begin
            n_bad++;
            $display("FAIL %s bit %0d: actual %b expected %b", tag, b, flags[b], v);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        quiet();
        rst_n = 0; cnt = 0; oa = 16'd100; ob = 16'd200; icr = 16'd300;
        cit = 0; omode = 1; mask = 8'hFF;
        exp_f = '0; hA = 0; hB = 0; hT = 0; pA = 0; pB = 0;
        #(CLK_PERIOD/4);
        step("R1 reset"); step("R1 reset");
        n_chk++;
        if (flags !== 8'h00 || irq !== 8'h00) begin
            n_bad++;
            $display("FAIL R1: actual %h/%h expected 00/00", flags, irq);
        end
        rst_n = 1;
        step("R1 idle");

        // R2: neighbour events land in their own bits
        t2c = 1; step("R2 t2c"); quiet(); expect_bit(7, 1, "R2 t2 cmp");
        t0o = 1; step("R2 t0o"); quiet(); expect_bit(0, 1, "R2 t0 ovf");
        t2o = 1; t0c = 1; step("R2 pair"); quiet();
        n_chk++;
        if (flags !== 8'b1100_0011) begin
            n_bad++;
            $display("FAIL R2 layout: actual %b expected 11000011", flags);
        end

        // R9: write zero keeps, write one clears
        wr = 1; wd = 8'h00; step("R9 zero"); quiet(); expect_bit(7, 1, "R9 zero write");
        wr = 1; wd = 8'h81; step("R9 one"); quiet();
        expect_bit(7, 0, "R9 clear 7"); expect_bit(6, 1, "R9 keep 6");

        // R10: acknowledge clears
        ack = 8'h42; step("R10 ack"); quiet();
        expect_bit(6, 0, "R10 ack 6"); expect_bit(1, 0, "R10 ack 1");

        // R11: set and clear in one cycle
        t0o = 1; wr = 1; wd = 8'h01; step("R11 wr"); quiet(); expect_bit(0, 1, "R11 set vs write");
        t0c = 1; ack = 8'h02; step("R11 ack"); quiet(); expect_bit(1, 1, "R11 set vs ack");

        // R3: capture pin with TOP from elsewhere
        cap = 1; step("R3 cap"); quiet(); expect_bit(5, 1, "R3 capture");
        wr = 1; wd = 8'hFF; step("clear all"); quiet();

        // R4: TOP from capture register ignores the pin
        cit = 1; icr = 16'd9; cnt = 16'd3;
        cap = 1; tick = 1; step("R4 pin"); quiet(); expect_bit(5, 0, "R4 pin ignored");
        cnt = 16'd9; tick = 1; step("R4 top"); quiet(); expect_bit(5, 1, "R4 top reached");
        cit = 0; wr = 1; wd = 8'hFF; step("clear all"); quiet();

        // R5: compare flag lags by one tick, with spaced ticks
        cnt = 16'd5; oa = 16'd5; ob = 16'd6;
        tick = 1; step("R5 match"); quiet(); expect_bit(4, 0, "R5 not in match tick");
        step("R5 gap"); step("R5 gap"); expect_bit(4, 0, "R5 waits for tick");
        tick = 1; step("R5 next"); quiet(); expect_bit(4, 1, "R5 next tick");

        // R6: held equality does not re-set after a clear
        wr = 1; wd = 8'h10; step("R6 clr"); quiet();
        for (int k = 0; k < 6; k++) begin
            tick = 1; step("R6 hold"); quiet();
        end
        expect_bit(4, 0, "R6 one shot");

        // R7: forced strobes alone never set
        cnt = 16'd0;
        fa = 1; fb = 1; step("R7 force"); quiet();
        tick = 1; fa = 1; fb = 1; step("R7 force tick"); quiet();
        tick = 1; step("R7 after"); quiet();
        expect_bit(4, 0, "R7 force A"); expect_bit(3, 0, "R7 force B");

        // R8: overflow gated by waveform mode
        omode = 0; ovf = 1; step("R8 off"); quiet(); expect_bit(2, 0, "R8 mode off");
        omode = 1; ovf = 1; step("R8 on"); quiet(); expect_bit(2, 1, "R8 mode on");

        // Seeded random run with small value ranges
        for (int n = 0; n < 4000; n++) begin
            tick  = ($urandom_range(0, 2) != 0);
            cnt   = 16'($urandom_range(0, 5));
            if ($urandom_range(0, 15) == 0) oa = 16'($urandom_range(0, 5));
            if ($urandom_range(0, 15) == 0) ob = 16'($urandom_range(0, 5));
            if ($urandom_range(0, 15) == 0) icr = 16'($urandom_range(0, 5));
            if ($urandom_range(0, 31) == 0) cit = ~cit;
            if ($urandom_range(0, 31) == 0) omode = ~omode;
            cap  = ($urandom_range(0, 7) == 0);
            ovf  = ($urandom_range(0, 7) == 0);
            fa   = ($urandom_range(0, 5) == 0);
            fb   = ($urandom_range(0, 5) == 0);
            t2c  = ($urandom_range(0, 9) == 0);
            t2o  = ($urandom_range(0, 9) == 0);
            t0c  = ($urandom_range(0, 9) == 0);
            t0o  = ($urandom_range(0, 9) == 0);
            wr   = ($urandom_range(0, 3) == 0);
            wd   = 8'($urandom_range(0, 255));
            ack  = ($urandom_range(0, 3) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
            mask = ($urandom_range(0, 63) == 0) ? 8'($urandom_range(0, 255)) : mask;
            step("rand");
        end
        quiet();
        done = 1;
        report();
    end
endmodule